// File: doc/BRIEF.md
# Snapshot Free-Running Counter

The block keeps a 64-bit up-counter that advances by one on every clock in which its count enable is high. Software cannot read the running value directly. Instead it works through three 32-bit registers on a simple write/read port: a low word, a high word and a control word.

Two bits of the control word are commands, and both clear themselves. The capture command copies the whole running count into the low and high words in one clock edge. Software can then read both halves with no risk of a carry slipping between the two reads. The clear command zeroes the low and high words. Software may also write the low and high words directly, and may store other bits in the control word.

Reads are combinational from the address. A write takes effect at the clock edge where `wr_en` is high.

Top module: `snap_counter64`

## Requirements
- R1: After reset, the low word (offset 0x0), the high word (offset 0x4) and the control word (offset 0x8) all read as zero.
- R2: The internal count starts at parameter `COUNT_RST` after reset. It rises by exactly one on each clock edge where `cnt_en` is 1 and holds where `cnt_en` is 0, as seen through captures.
- R3: A control write with bit 1 (capture) set and bit 0 clear loads the count as it stood just before that edge. Bits [31:0] go to the low word and bits [63:32] to the high word, and both are readable from the next cycle.
- R4: The capture bit (bit 1) of the control word always reads back as 0 after the write that set it.
- R5: A control write with bit 0 (clear) set zeroes the low and high words, and bit 0 reads back as 0.
- R6: A control write with both bit 1 and bit 0 set leaves the low and high words at zero.
- R7: Writes to offset 0x0 or 0x4 replace only that word. They do not disturb the other word or the running count.
- R8: Control bits other than bits 1 and 0 keep the last value written and read back unchanged.
- R9: Any offset other than 0x0, 0x4 and 0x8 reads as zero, and writes to such an offset change no register.
- R10: With no write, the low and high words hold their value while the count keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable for the running counter |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data for `addr`, combinational |

## Verification
The running count is hidden, so a wrong count only shows up at the next capture. A missed or extra increment then appears as a low word that is off by the number of bad cycles. Carry faults appear only once the count crosses a 32-bit boundary, so the bench starts the count just below one. A capture that takes the post-increment value, or a command bit that fails to clear itself, shows on the very next read. The priority between a clear and a capture in the same write shows in the first read after a combined write.

// File: rtl/snap_counter64.sv
`timescale 1ns/1ps
module snap_counter64 #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4,
  parameter int CAP_BIT = 1,
  parameter int CLR_BIT = 0,
  parameter logic [2*REG_W-1:0] COUNT_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata
);
  localparam int CNT_W = 2 * REG_W;
  localparam logic [ADDR_W-1:0] LO_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] HI_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(8);
  localparam logic [REG_W-1:0]  CMD_MASK = (REG_W'(1) << CAP_BIT) | (REG_W'(1) << CLR_BIT);

  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-1:0] lo_q, hi_q, ctl_q;

  wire sel_lo  = wr_en && (addr == LO_OFS);
  wire sel_hi  = wr_en && (addr == HI_OFS);
  wire sel_ctl = wr_en && (addr == CTL_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= COUNT_RST;
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_q + CNT_W'(1);
      if (sel_lo) lo_q <= wdata;
      if (sel_hi) hi_q <= wdata;
      if (sel_ctl) begin
        ctl_q <= wdata & ~CMD_MASK;
        if (wdata[CLR_BIT]) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (wdata[CAP_BIT]) begin
          lo_q <= cnt_q[REG_W-1:0];
          hi_q <= cnt_q[CNT_W-1:REG_W];
        end
      end
    end
  end

  always_comb begin
    case (addr)
      LO_OFS:  rdata = lo_q;
      HI_OFS:  rdata = hi_q;
      CTL_OFS: rdata = ctl_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/snap_counter64_chk.sv
`timescale 1ns/1ps
module snap_counter64_chk #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 4,
  parameter int CAP_BIT = 1,
  parameter int CLR_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [REG_W-1:0]  wdata,
  input logic [2*REG_W-1:0] cnt_q,
  input logic [REG_W-1:0]  lo_q,
  input logic [REG_W-1:0]  hi_q,
  input logic [REG_W-1:0]  ctl_q
);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(8);
  wire ctl_wr = wr_en && (addr == CTL_OFS);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_q == $past(cnt_q) + 1'b1);

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[CAP_BIT] && !wdata[CLR_BIT]) |=> {hi_q, lo_q} == $past(cnt_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[CLR_BIT]) |=> (lo_q == '0 && hi_q == '0));

  // R4
  cmd_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!ctl_q[CAP_BIT] && !ctl_q[CLR_BIT]));

  // R10
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q)));
endmodule

bind snap_counter64 snap_counter64_chk #(
  .REG_W(REG_W), .ADDR_W(ADDR_W), .CAP_BIT(CAP_BIT), .CLR_BIT(CLR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .cnt_q(cnt_q), .lo_q(lo_q), .hi_q(hi_q), .ctl_q(ctl_q)
);

// File: tb/snap_counter64_bench.sv
`timescale 1ns/1ps
module snap_counter64_bench;
  localparam logic [63:0] CINIT = 64'h0000_0002_FFFF_FFF8;
  localparam logic [3:0] A_LO = 4'h0, A_HI = 4'h4, A_CTL = 4'h8;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0, failures = 0;
  logic [63:0] m;
  logic [63:0] snap;

  always #2.5 clk = ~clk;

  snap_counter64 #(.COUNT_RST(CINIT)) u_snap_counter64 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) m <= CINIT;
    else if (cnt_en) m <= m + 64'd1;
  end

  // wa(4) wd(32) ra(4) exp(32) req(4)
  localparam int NV = 8;
  localparam logic [75:0] VEC [NV] = '{
    {A_LO,  32'hDEAD_BEEF, A_LO,  32'hDEAD_BEEF, 4'd7},  // R7
    {A_HI,  32'h1234_5678, A_HI,  32'h1234_5678, 4'd7},  // R7
    {A_LO,  32'h0000_0000, A_HI,  32'h1234_5678, 4'd7},  // R7
    {4'hC,  32'hFFFF_FFFF, 4'hC,  32'h0000_0000, 4'd9},  // R9
    {4'hC,  32'h0000_AAAA, A_HI,  32'h1234_5678, 4'd9},  // R9
    {A_CTL, 32'hF0F0_F0FC, A_CTL, 32'hF0F0_F0FC, 4'd8},  // R8
    {A_CTL, 32'h0000_0101, A_CTL, 32'h0000_0100, 4'd5},  // R5
    {4'h2,  32'h5555_5555, A_HI,  32'h0000_0000, 4'd5}   // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; snap = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, lo1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_LO, v);  check("R1 low", v, 32'h0);
    rd(A_HI, v);  check("R1 high", v, 32'h0);
    rd(A_CTL, v); check("R1 ctl", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:72], VEC[i][71:40]);
      rd(VEC[i][39:36], v);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), v, VEC[i][35:4]);
    end

    // R2 R3: capture with count idle equals start value
    wr(A_CTL, 32'h2);
    rd(A_LO, v); check("R3 low idle", v, CINIT[31:0]);
    rd(A_HI, v); check("R3 high idle", v, CINIT[63:32]);
    rd(A_CTL, v); check("R4 ctl after capture", v, 32'h0);

    // R2: run across the 32-bit carry, then capture
    @(negedge clk); cnt_en = 1'b1;
    repeat (20) @(negedge clk);
    wr(A_CTL, 32'h0000_0A02);
    rd(A_LO, v); check("R3 low run", v, snap[31:0]);
    rd(A_HI, v); check("R3 high carry", v, snap[63:32]);
    check("R2 carry reached", v, 32'h3);
    rd(A_CTL, v); check("R4 R8 ctl", v, 32'h0000_0A00);

    // R10: snapshot holds while count runs
    rd(A_LO, lo1);
    repeat (7) @(negedge clk);
    rd(A_LO, v); check("R10 hold", v, lo1);

    // R2: stop, two captures give same value
    cnt_en = 1'b0;
    wr(A_CTL, 32'h2); rd(A_LO, lo1);
    repeat (4) @(negedge clk);
    wr(A_CTL, 32'h2); rd(A_LO, v);
    check("R2 stopped", v, lo1);

    // R7: direct write does not disturb count
    wr(A_LO, 32'hCAFE_0000);
    wr(A_CTL, 32'h2); rd(A_LO, v);
    check("R7 count intact", v, lo1);

    // R6: both commands
    cnt_en = 1'b1;
    wr(A_CTL, 32'h3);
    rd(A_LO, v); check("R6 low", v, 32'h0);
    rd(A_HI, v); check("R6 high", v, 32'h0);
    rd(A_CTL, v); check("R6 ctl", v, 32'h0);

    // R5: clear after a capture
    wr(A_CTL, 32'h2);
    wr(A_CTL, 32'h1);
    rd(A_HI, v); check("R5 high", v, 32'h0);
    rd(4'h1, v); check("R9 unaligned", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule